// File: doc/BRIEF.md
# Multiplexed Channel Context Sequencer

Several I/O devices share one channel. For each device the sequencer keeps a small context: a state code, a memory address and a two-bit order. These live in three memories indexed by device number. A device asks for service by raising its request line. The sequencer latches the request and picks the lowest-numbered latched device. It copies that device's context into working registers and then makes one memory transfer request to the I/O processor. The request is a strobe (S1), a command code and an address on the outgoing data bus.

When the processor answers with its output strobe (SO) and a data word, the sequencer writes the updated context back for that device. There are three kinds of service:

- **Table fetch.** The data word becomes the device's program address.
- **Control-word fetch.** The order bits are taken from the data word.
- **Address-word transfer.** This finishes one program word and advances the address.

While any request is latched, the daisy-chained data poll is not passed further down the chain. The memory, the processor and the device controllers are outside the block and appear only as handshake signals.

Top module: `chan_ctx_seq`

## Requirements
- R1: After reset, s1_o is 0, cmd_o is 0 (none), bus_o is 0, and the first service of every device is a table fetch.
- R2: In a table fetch, S1 is raised with cmd_o = 1, and bus_o carries the device number shifted left by two (device number times four). Each device therefore owns four table words.
- R3: The word returned with SO at the end of a table fetch becomes the device's address. The device's next service is a control-word fetch: cmd_o = 2 (read from memory) with that address on bus_o.
- R4: In the word returned for a control-word fetch, bit 15 means store and bit 14 means last. The next service is an address-word transfer at address + 1, with cmd_o = 3 (write to memory) if store is set and cmd_o = 2 otherwise.
- R5: After an address-word transfer, the next service depends on the last flag. If it is clear, the next service is a control-word fetch at address + 2 (relative to the control word). If it is set, the device returns to idle, and its next service is a table fetch again.
- R6: S1, cmd_o and bus_o stay stable until SO is sampled high. S1 falls on the clock after that.
- R7: A request is latched on a clock while the sequencer is idle. The latch clears when SO falls for that device. If the request is still high, it is latched again on the following clock, giving back-to-back services.
- R8: poll_o follows poll_i while no request is latched, and is 0 while any request is latched.
- R9: A request that rises and falls while a service is in progress (S1 high, or SO not yet fallen) is ignored and causes no service.
- R10: Among several latched requests, the lowest device number is serviced first.
- R11: Each device's context is kept separately. Servicing one device never changes what another device's next service requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srv_req_i | input | NUM_DEV | Per-device service request |
| poll_i | input | 1 | Data poll from upstream |
| poll_o | output | 1 | Data poll to downstream, blocked while a request is latched |
| so_i | input | 1 | Processor output strobe closing a transfer |
| data_i | input | DATA_W | Word returned by the processor with SO |
| s1_o | output | 1 | Response strobe requesting a transfer |
| cmd_o | output | 2 | Command: 0 none, 1 table fetch, 2 read memory, 3 write memory |
| bus_o | output | DATA_W | Transfer address while S1 is high, else 0 |

## Verification
Some properties are checked by assertions on every cycle:
- the S1/command/address hold until SO, and the S1 drop one clock after SO;
- four-word alignment of every table address;
- poll blocking whenever S1 is high;
- request latches setting only while the sequencer is idle.

The bench scenarios cover what only a sequence of services can show. These are the progression of one device through table, control-word and address-word transfers, the store and last decoding of the control word, and the return to a table fetch after a last word. They also cover lowest-number priority, a request pulse dropped during a busy service, and contexts of different devices staying apart across interleaved services.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef enum logic [1:0] {
    CTX_IDLE = 2'd0,
    CTX_TBL  = 2'd1,
    CTX_CWF  = 2'd2,
    CTX_AWX  = 2'd3
  } ctx_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_TBL  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_WR   = 2'd3
  } chan_cmd_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_e;

  localparam int ORD_W     = 2;
  localparam int ORD_STORE = 1;
  localparam int ORD_LAST  = 0;
endpackage

// File: rtl/chan_req_latch.sv
module chan_req_latch #(
  parameter int NUM_DEV = 16,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] req_i,
  input  logic               busy_i,
  input  logic               clr_i,
  input  logic [DEV_W-1:0]   clr_idx_i,
  output logic [NUM_DEV-1:0] sr_o
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               sr_o[g] <= 1'b0;
      else if (clr_i && clr_idx_i == DEV_W'(g))  sr_o[g] <= 1'b0;
      else if (!busy_i && req_i[g])              sr_o[g] <= 1'b1;
    end

    // R9
    set_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sr_o[g]) |-> !$past(busy_i));
  end
endmodule

// File: rtl/chan_pick.sv
module chan_pick #(
  parameter int NUM_DEV = 16,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0] req_i,
  output logic               any_o,
  output logic [DEV_W-1:0]   idx_o
);
  // descending scan: last hit is the lowest number
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = DEV_W'(i);
      end
    end
  end
endmodule

// File: rtl/chan_ctx_ram.sv
module chan_ctx_ram #(
  parameter int DEPTH          = 16,
  parameter int W              = 16,
  parameter logic [W-1:0] INIT = '0,
  localparam int AW            = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/chan_ctx_seq.sv
module chan_ctx_seq
  import chan_seq_pkg::*;
#(
  parameter int NUM_DEV       = 16,
  parameter int DATA_W        = 16,
  parameter int WORDS_PER_DEV = 4,
  localparam int DEV_W        = $clog2(NUM_DEV),
  localparam int TBL_SHIFT    = $clog2(WORDS_PER_DEV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] srv_req_i,
  input  logic               poll_i,
  output logic               poll_o,
  input  logic               so_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               s1_o,
  output logic [1:0]         cmd_o,
  output logic [DATA_W-1:0]  bus_o
);
  seq_e              seq_q;
  ctx_st_e           st_q;
  logic [DATA_W-1:0] addr_q;
  logic [ORD_W-1:0]  ord_q;
  logic [DEV_W-1:0]  cur_q;

  logic [NUM_DEV-1:0] sr;
  logic               pick_any;
  logic [DEV_W-1:0]   pick_idx;

  logic [1:0]        st_rd;
  logic [DATA_W-1:0] addr_rd;
  logic [ORD_W-1:0]  ord_rd;

  logic              wb_en;
  ctx_st_e           st_wd;
  logic [DATA_W-1:0] addr_wd;
  logic [ORD_W-1:0]  ord_wd;

  logic busy, clr;

  assign busy  = (seq_q != SEQ_IDLE);
  assign clr   = (seq_q == SEQ_DONE) && !so_i;   // trailing edge of SO
  assign wb_en = (seq_q == SEQ_RUN) && so_i;

  chan_req_latch #(.NUM_DEV(NUM_DEV)) u_lat (
    .clk_i, .rst_ni, .req_i(srv_req_i), .busy_i(busy),
    .clr_i(clr), .clr_idx_i(cur_q), .sr_o(sr)
  );

  chan_pick #(.NUM_DEV(NUM_DEV)) u_pick (
    .req_i(sr), .any_o(pick_any), .idx_o(pick_idx)
  );

  chan_ctx_ram #(.DEPTH(NUM_DEV), .W(2), .INIT(CTX_IDLE)) u_st_ram (
    .clk_i, .rst_ni, .we_i(wb_en), .waddr_i(cur_q), .wdata_i(st_wd),
    .raddr_i(pick_idx), .rdata_o(st_rd)
  );

  chan_ctx_ram #(.DEPTH(NUM_DEV), .W(DATA_W)) u_addr_ram (
    .clk_i, .rst_ni, .we_i(wb_en), .waddr_i(cur_q), .wdata_i(addr_wd),
    .raddr_i(pick_idx), .rdata_o(addr_rd)
  );

  chan_ctx_ram #(.DEPTH(NUM_DEV), .W(ORD_W)) u_ord_ram (
    .clk_i, .rst_ni, .we_i(wb_en), .waddr_i(cur_q), .wdata_i(ord_wd),
    .raddr_i(pick_idx), .rdata_o(ord_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_IDLE;
      st_q   <= CTX_IDLE;
      addr_q <= '0;
      ord_q  <= '0;
      cur_q  <= '0;
    end else begin
      unique case (seq_q)
        SEQ_IDLE: if (pick_any) begin
          cur_q  <= pick_idx;
          st_q   <= ctx_st_e'(st_rd);
          addr_q <= addr_rd;
          ord_q  <= ord_rd;
          seq_q  <= SEQ_RUN;
        end
        SEQ_RUN:  if (so_i)  seq_q <= SEQ_DONE;
        SEQ_DONE: if (!so_i) seq_q <= SEQ_IDLE;
        default:  seq_q <= SEQ_IDLE;
      endcase
    end
  end

  // context write-back on SO
  always_comb begin
    st_wd   = CTX_CWF;
    addr_wd = addr_q + DATA_W'(1);
    ord_wd  = ord_q;
    unique case (st_q)
      CTX_IDLE, CTX_TBL: addr_wd = data_i;
      CTX_CWF: begin
        st_wd  = CTX_AWX;
        ord_wd = data_i[DATA_W-1 -: ORD_W];
      end
      CTX_AWX: st_wd = ord_q[ORD_LAST] ? CTX_IDLE : CTX_CWF;
      default: ;
    endcase
  end

  logic [DATA_W-1:0] tbl_addr;
  assign tbl_addr = DATA_W'({cur_q, {TBL_SHIFT{1'b0}}});

  always_comb begin
    cmd_o = CMD_NONE;
    bus_o = '0;
    if (seq_q == SEQ_RUN) begin
      unique case (st_q)
        CTX_IDLE, CTX_TBL: begin cmd_o = CMD_TBL; bus_o = tbl_addr; end
        CTX_CWF:           begin cmd_o = CMD_RD;  bus_o = addr_q;   end
        CTX_AWX: begin
          cmd_o = ord_q[ORD_STORE] ? CMD_WR : CMD_RD;
          bus_o = addr_q;
        end
        default: ;
      endcase
    end
  end

  assign s1_o   = (seq_q == SEQ_RUN);
  assign poll_o = poll_i && (sr == '0);

  // R6
  s1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_o && !so_i |=> s1_o && $stable(bus_o) && $stable(cmd_o));

  // R6
  s1_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_o && so_i |=> !s1_o);

  // R2
  tbl_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_o && cmd_o == CMD_TBL |-> bus_o[TBL_SHIFT-1:0] == '0);

  // R8
  poll_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_o |-> !poll_o);
endmodule

// File: tb/chan_ctx_seq_test.sv
module chan_ctx_seq_test;
  localparam int NUM_DEV = 16;
  localparam int DATA_W  = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_DEV-1:0] req = '0;
  logic               poll_in = 1'b1;
  logic               poll_out;
  logic               so = 1'b0;
  logic [DATA_W-1:0]  data = '0;
  logic               s1;
  logic [1:0]         cmd;
  logic [DATA_W-1:0]  bus;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [1:0]  cmd;
    logic [15:0] bus;
    logic [15:0] reply;
    int          dev;
    bit          last;
  } item_t;

  item_t exp_q[$];

  always #5 clk = ~clk;

  chan_ctx_seq #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .srv_req_i(req), .poll_i(poll_in),
    .poll_o(poll_out), .so_i(so), .data_i(data), .s1_o(s1),
    .cmd_o(cmd), .bus_o(bus)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(string tag, logic [1:0] c, logic [15:0] b,
                      logic [15:0] r, int dev, bit last);
    item_t it;
    it.tag = tag; it.cmd = c; it.bus = b; it.reply = r;
    it.dev = dev; it.last = last;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor + processor responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && s1) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R9: actual unexpected S1 cmd %h bus %h expected none", cmd, bus);
          @(negedge clk);
          so = 1'b1;
          @(negedge clk);
          so = 1'b0;
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(it.tag, {14'd0, cmd, bus}, {14'd0, it.cmd, it.bus});
          chk("R8 poll blocked", {31'd0, poll_out}, 32'd0);
          @(negedge clk);
          chk("R6 held", {14'd0, s1, cmd, bus}, {14'd0, 1'b1, it.cmd, it.bus});
          so = 1'b1;
          data = it.reply;
          if (it.last) req[it.dev] = 1'b0;
          @(negedge clk);
          chk("R6 s1 drop", {31'd0, s1}, 32'd0);
          so = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 s1", {31'd0, s1}, 32'd0);
    chk("R1 cmd", {30'd0, cmd}, 32'd0);
    chk("R1 bus", {16'd0, bus}, 32'd0);
    chk("R8 poll pass", {31'd0, poll_out}, 32'd1);
    poll_in = 1'b0;
    @(negedge clk);
    chk("R8 poll low", {31'd0, poll_out}, 32'd0);
    poll_in = 1'b1;

    // device 5 walks a program, request held throughout (R7)
    push("R2 R1 dev5 table", 2'd1, 16'h0014, 16'h0100, 5, 0);
    push("R3 dev5 cw fetch", 2'd2, 16'h0100, 16'h8000, 5, 0);
    push("R4 dev5 aw store", 2'd3, 16'h0101, 16'h1234, 5, 0);
    push("R5 dev5 next cw",  2'd2, 16'h0102, 16'h4000, 5, 0);
    push("R4 dev5 aw read",  2'd2, 16'h0103, 16'hBEEF, 5, 0);
    push("R5 R7 dev5 retable", 2'd1, 16'h0014, 16'h0500, 5, 1);
    req[5] = 1'b1;
    drain();

    // R10 two devices at once
    push("R10 dev2 first", 2'd1, 16'h0008, 16'h0200, 2, 1);
    push("R10 dev9 second", 2'd1, 16'h0024, 16'h0300, 9, 1);
    req[2] = 1'b1;
    req[9] = 1'b1;
    drain();

    // R2 highest device
    push("R2 dev15 table", 2'd1, 16'h003C, 16'h0F00, 15, 1);
    req[15] = 1'b1;
    drain();

    // R9 pulse during busy service
    push("R9 dev7 table", 2'd1, 16'h001C, 16'h0700, 7, 1);
    req[7] = 1'b1;
    while (!s1) @(negedge clk);
    req[3] = 1'b1;
    @(negedge clk);
    req[3] = 1'b0;
    drain();
    chk("R9 no latch left", {31'd0, poll_out}, 32'd1);
    chk("R9 idle", {31'd0, s1}, 32'd0);

    // R11 contexts stay apart
    push("R11 dev9 cw", 2'd2, 16'h0300, 16'hC000, 9, 0);
    push("R4 dev9 aw store", 2'd3, 16'h0301, 16'h5555, 9, 1);
    req[9] = 1'b1;
    drain();
    push("R11 dev2 cw", 2'd2, 16'h0200, 16'h0000, 2, 1);
    req[2] = 1'b1;
    drain();
    push("R5 R11 dev9 after last", 2'd1, 16'h0024, 16'h0900, 9, 1);
    req[9] = 1'b1;
    drain();

    chk("R8 final poll", {31'd0, poll_out}, 32'd1);
    finish_run();
  end
endmodule